// File: doc/BRIEF.md
# Shared-Memory Command Mailbox Engine

This block is the peripheral-side controller for a command mailbox that lives in a byte-wide RAM shared with a host processor. When it leaves reset it stores a version code and a clean startup status in the RAM, then pulses a strobe that sets the host-visible ready flag. From then on it polls one command byte in the RAM at a fixed interval.

A command is any byte with bit 7 set. Codes from 0x80 to 0x89 are executed. Each one is modelled as an operation with a fixed latency. Codes with bit 7 set that lie above that range are rejected. In both cases the engine writes a result byte into an error-status location and then writes zero over the command byte. The host learns that its command was taken by seeing that zero. Bytes with bit 7 clear are not commands and are left untouched. One code, 0x87, turns off the engine's interrupt-enable output.

The engine holds no RAM of its own. It drives a single port into the shared memory. That port has a one-cycle read latency.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After reset the engine writes VERSION (default 0xA8) to RAM index 0x0A, then writes 0x00 to the startup status at index 0x0B, and only then pulses `ready_set`.
- R2: `ready_set` is high for exactly one cycle per reset and is never raised again until the next reset.
- R3: While no command is pending, the engine reads the command byte at index 0x00 once every POLL_N+2 cycles.
- R4: A command byte in the range 0x00 to 0x7F (bit 7 clear) is left unchanged, and the status at index 0x08 is not written.
- R5: A code from 0x80 to 0x89 is executed. At least CMD_LAT cycles later the engine writes 0x00 to index 0x08 and then writes 0x00 to the command byte.
- R6: A code from 0x8A to 0xFF is rejected. The engine writes status 0x01 to index 0x08 and then writes 0x00 to the command byte.
- R7: `irq_en` is 1 after reset. Code 0x87 clears it and completes with status 0x00. No other code changes it.
- R8: The status write to index 0x08 happens in the cycle just before the command byte is cleared, so the host never sees a cleared command without its result.
- R9: The engine never asserts a RAM read and a RAM write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_addr | output | AW | Shared RAM byte index |
| ram_wdata | output | 8 | Write data |
| ram_we | output | 1 | Write enable |
| ram_re | output | 1 | Read enable; data arrives the next cycle |
| ram_rdata | input | 8 | Read data |
| ready_set | output | 1 | One-cycle strobe that sets the ready flag |
| irq_en | output | 1 | Interrupt-enable state |

## Verification
Most wrong states in the sequencer show up at the RAM port within one poll period. Examples are a missed wait, a mis-decoded range edge or a lost command code. The symptom is a command byte that is never zeroed, a status byte with the wrong value, or a read cadence that is off by a cycle. The directed tests probe both edges of the accepted range (0x80/0x89 and 0x8A), the 0x7F/0x80 boundary of bit 7, and the order of the two completion writes. A wrong interrupt-enable state is visible at once on `irq_en` after the disabling command completes.

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine #(
  parameter int AW        = 9,
  parameter int POLL_N    = 16,
  parameter int CMD_LAT   = 8,
  parameter logic [7:0] VERSION  = 8'hA8,
  parameter logic [7:0] CMD_LO   = 8'h80,
  parameter logic [7:0] CMD_HI   = 8'h89,
  parameter logic [7:0] DIS_CODE = 8'h87,
  parameter int CMD_IDX   = 0,
  parameter int ERR_IDX   = 8,
  parameter int VER_IDX   = 10,
  parameter int START_IDX = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  input  logic [7:0]    ram_rdata,
  output logic          ready_set,
  output logic          irq_en
);
  localparam int MAXW = (POLL_N > CMD_LAT) ? POLL_N : CMD_LAT;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [3:0] {
    S_VER, S_START, S_RDY, S_IDLE, S_RD, S_EVAL, S_BUSY, S_STAT, S_CLR
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [7:0]   code_q;
  logic [7:0]   stat_q;
  logic         seen_rdy;

  wire in_range = (ram_rdata >= CMD_LO) && (ram_rdata <= CMD_HI);

  always_comb begin
    ram_addr  = AW'(CMD_IDX);
    ram_wdata = 8'h00;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    case (st)
      S_VER:   begin ram_we = 1'b1; ram_addr = AW'(VER_IDX); ram_wdata = VERSION; end
      S_START: begin ram_we = 1'b1; ram_addr = AW'(START_IDX); end
      S_RD:    ram_re = 1'b1;
      S_STAT:  begin ram_we = 1'b1; ram_addr = AW'(ERR_IDX); ram_wdata = stat_q; end
      S_CLR:   ram_we = 1'b1;
      default: ;
    endcase
  end

  assign ready_set = (st == S_RDY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_VER;
      cnt      <= '0;
      code_q   <= 8'h00;
      stat_q   <= 8'h00;
      irq_en   <= 1'b1;
      seen_rdy <= 1'b0;
    end else begin
      if (ready_set) seen_rdy <= 1'b1;
      case (st)
        S_VER:   st <= S_START;
        S_START: st <= S_RDY;
        S_RDY:   begin st <= S_IDLE; cnt <= '0; end
        S_IDLE:
          if (cnt == CW'(POLL_N - 1)) begin cnt <= '0; st <= S_RD; end
          else cnt <= cnt + 1'b1;
        S_RD:    st <= S_EVAL;
        S_EVAL:
          if (!ram_rdata[7]) begin
            st <= S_IDLE; cnt <= '0;
          end else begin
            code_q <= ram_rdata;
            stat_q <= in_range ? 8'h00 : 8'h01;
            cnt    <= '0;
            st     <= in_range ? S_BUSY : S_STAT;
          end
        S_BUSY:
          if (cnt == CW'(CMD_LAT - 1)) begin
            if (code_q == DIS_CODE) irq_en <= 1'b0;
            st <= S_STAT;
          end else cnt <= cnt + 1'b1;
        S_STAT:  st <= S_CLR;
        S_CLR:   begin st <= S_IDLE; cnt <= '0; end
        default: st <= S_VER;
      endcase
    end
  end

  a_r9_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
  a_r2_ready_once: assert property (@(posedge clk) disable iff (!rst_n)
    ready_set |-> !seen_rdy);
  a_r1_ready_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ready_set |-> ($past(ram_we) && $past(ram_addr) == AW'(START_IDX) && $past(ram_wdata) == 8'h00));
  a_r8_status_before_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == AW'(CMD_IDX)) |-> ($past(ram_we) && $past(ram_addr) == AW'(ERR_IDX)));
  a_r8_clear_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == AW'(CMD_IDX)) |-> ram_wdata == 8'h00);
  a_r6_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == AW'(ERR_IDX)) |-> ram_wdata <= 8'h01);
  a_r7_irq_only_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_en) |-> code_q == DIS_CODE);
  a_r3_reads_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> !ram_re);
endmodule

// File: tb/sim_mbox_cmd_engine.sv
module sim_mbox_cmd_engine;
  localparam int CLK_P = 10;
  localparam int POLL_N = 16;
  localparam int CMD_LAT = 8;
  localparam int AW = 9;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;
  logic ram_we, ram_re, ready_set, irq_en;

  logic [7:0] mem [0:(1<<AW)-1];
  logic host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;

  int n_chk = 0, n_fail = 0;
  int rdy_cnt = 0, order_bad = 0, cyc = 0, rd_prev = -1, rd_last = -1;
  int last_we_addr = -1;

  always #(CLK_P/2) clk = ~clk;

  mbox_cmd_engine #(.AW(AW), .POLL_N(POLL_N), .CMD_LAT(CMD_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata),
    .ready_set(ready_set), .irq_en(irq_en));

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (ready_set) rdy_cnt <= rdy_cnt + 1;
      if (ram_re && ram_addr == 0) begin rd_prev <= rd_last; rd_last <= cyc; end
      if (ram_we) begin
        if (ram_addr == 0 && last_we_addr != 8) order_bad <= order_bad + 1;
        last_we_addr <= int'(ram_addr);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int idx, input logic [7:0] v);
    @(negedge clk);
    host_we = 1; host_addr = AW'(idx); host_wdata = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic t_reset;
    host_wr(10, 8'h00);
    host_wr(11, 8'hEE);
    host_wr(0, 8'h00);
    host_wr(8, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (10) @(negedge clk);
    check(mem[10] == 8'hA8, "R1 version", mem[10], 8'hA8);
    check(mem[11] == 8'h00, "R1 startup status", mem[11], 8'h00);
    check(rdy_cnt == 1, "R2 ready pulse", rdy_cnt, 1);
    check(irq_en == 1'b1, "R7 irq_en reset", irq_en, 1);
  endtask

  task automatic t_poll;
    repeat (3*(POLL_N+2)) @(negedge clk);
    check(rd_last - rd_prev == POLL_N+2, "R3 poll period", rd_last - rd_prev, POLL_N+2);
    check(rdy_cnt == 1, "R2 no second ready", rdy_cnt, 1);
  endtask

  task automatic t_passive(input logic [7:0] v);
    host_wr(8, 8'h33);
    host_wr(0, v);
    repeat (3*(POLL_N+2)) @(negedge clk);
    check(mem[0] == v, "R4 non-command kept", mem[0], v);
    check(mem[8] == 8'h33, "R4 status untouched", mem[8], 8'h33);
  endtask

  task automatic run_cmd(input logic [7:0] v, output int lat);
    host_wr(8, 8'h55);
    host_wr(0, v);
    lat = 0;
    for (int i = 0; i < 400; i++) begin
      if (mem[0] == 8'h00) break;
      @(negedge clk); lat++;
    end
  endtask

  task automatic t_valid(input logic [7:0] v);
    int lat;
    run_cmd(v, lat);
    check(mem[0] == 8'h00, "R5 command cleared", mem[0], 0);
    check(mem[8] == 8'h00, "R5 status ok", mem[8], 0);
    check(lat >= CMD_LAT, "R5 latency", lat, CMD_LAT);
    check(irq_en == 1'b1, "R7 irq_en kept", irq_en, 1);
  endtask

  task automatic t_invalid(input logic [7:0] v);
    int lat;
    run_cmd(v, lat);
    check(mem[0] == 8'h00, "R6 command cleared", mem[0], 0);
    check(mem[8] == 8'h01, "R6 invalid status", mem[8], 1);
    check(irq_en == 1'b1, "R7 irq_en kept", irq_en, 1);
  endtask

  task automatic t_disable;
    int lat;
    run_cmd(8'h87, lat);
    check(mem[0] == 8'h00, "R7 command cleared", mem[0], 0);
    check(mem[8] == 8'h00, "R7 status ok", mem[8], 0);
    check(irq_en == 1'b0, "R7 irq_en cleared", irq_en, 0);
  endtask

  task automatic t_order;
    check(order_bad == 0, "R8 status before clear", order_bad, 0);
    check(rdy_cnt == 1, "R2 single ready", rdy_cnt, 1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    t_reset();
    t_poll();
    t_passive(8'h00);
    t_passive(8'h7F);
    t_passive(8'h42);
    t_valid(8'h80);
    t_valid(8'h89);
    t_valid(8'h84);
    t_invalid(8'h8A);
    t_invalid(8'hFF);
    t_invalid(8'hC0);
    t_disable();
    t_order();
    // R9 is covered by the a_r9_no_rw_clash property in the design
    summary();
  end
endmodule